// File: doc/BRIEF.md
# Time-Hit Record Packer

This block sits behind a multichannel time digitizer. It turns each hit into one or two 32-bit words on a valid/ready output stream. A hit carries a 4-bit channel, a 5-bit crate number, a 5-bit card number and a 12-bit measured time. Every record also carries a module identifier taken from a configuration input.

The block picks the record form per hit:

- When the identifier fits in 5 bits, it emits a single self-contained word flagged by a 1 in bit 31.
- When the identifier is wider, it emits a two-word record flagged by a 0 in bit 31. The head word holds the full 14-bit identifier and a word count. The body word holds the hit fields.

Hits from channels masked off, and optionally hits whose time is zero, are consumed without producing output.

The input hit is handshaken only once its last output word has been taken. The two words of a long record therefore always leave back to back for the same hit. Nothing is buffered: the output words are formed combinationally from the hit presented at the input, and a one-bit phase register remembers whether the head of a long record has already gone.

Top module: `hitrec_packer`

## Requirements
- R1: When `cfg_modid` is below 32, a passed hit produces exactly one word. That word has bit 31 = 1, `cfg_modid[4:0]` in bits 30:26, crate in 25:21, card in 20:16, channel in 15:12 and time value in 11:0, with `rec_last` = 1.
- R2: When `cfg_modid` is 32 or more, the first word of the record has bit 31 = 0, the 14-bit identifier in bits 30:17 and the value 2 in bits 16:0, with `rec_last` = 0.
- R3: The second word of a long record has bits 31:26 = 0 and crate, card, channel and time value in the same bit positions as the short word, with `rec_last` = 1.
- R4: After the first word of a long record is transferred, the second word is presented in the very next cycle.
- R5: A hit whose channel bit in `cfg_chan_en` is 0 produces no word, and `hit_ready` is 1 in the same cycle, so the hit is consumed at once.
- R6: With `cfg_drop_zero` = 1, a hit whose time value is 0 produces no word and is consumed at once. With `cfg_drop_zero` = 0, such a hit is packed normally.
- R7: While `rec_valid` is 1 and `rec_ready` is 0, `rec_data` and `rec_last` stay unchanged into the next cycle.
- R8: For a passed hit, `hit_ready` is 1 only in the cycle in which the word with `rec_last` = 1 is transferred.
- R9: While `rst_n` is 0, `rec_valid` and `hit_ready` are 0 whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | A hit is presented |
| hit_ready | output | 1 | Hit consumed this cycle |
| hit_chan | input | 4 | Channel number of the hit |
| hit_crate | input | 5 | Crate number |
| hit_card | input | 5 | Card number |
| hit_value | input | 12 | Measured time value |
| cfg_modid | input | 14 | Module identifier |
| cfg_chan_en | input | 16 | Per-channel enable, bit n for channel n |
| cfg_drop_zero | input | 1 | Suppress hits whose time value is zero |
| rec_valid | output | 1 | Output word valid |
| rec_ready | input | 1 | Downstream takes the word |
| rec_data | output | 32 | Output word |
| rec_last | output | 1 | Word is the final one of its record |

## Verification
The hold and back-to-back properties assume two things about the upstream side:

- A presented hit, together with the configuration inputs, stays constant until `hit_ready` is seen.
- `hit_valid` is not withdrawn before the hit is consumed.

The output words depend combinationally on those inputs, so the properties rely on this. The bench respects it by changing hit fields and configuration only on the falling edge right after a consuming clock edge.

The bench applies back-pressure of zero to two stall cycles per word. It sweeps all sixteen channels with a mixed enable mask, time values at zero, mid-range and full scale, and identifiers on both sides of the 5-bit boundary, with the zero-drop option off and on.

// File: rtl/hitrec_pkg.sv
package hitrec_pkg;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned LEN_W    = 17;
   localparam int unsigned LONG_LEN = 2;

   typedef enum logic {
      PH_HEAD = 1'b0,
      PH_BODY = 1'b1
   } phase_e;
endpackage

// File: rtl/hitrec_gate.sv
module hitrec_gate #(
   parameter int unsigned CHAN_W = 4,
   parameter int unsigned VAL_W  = 12,
   localparam int unsigned NCHAN = 1 << CHAN_W
) (
   input  logic [CHAN_W-1:0] chan,
   input  logic [VAL_W-1:0]  value,
   input  logic [NCHAN-1:0]  chan_en,
   input  logic              drop_zero,
   output logic              pass
);
   logic online;
   logic zero_hit;

   always_comb begin
      online   = chan_en[chan];
      zero_hit = (value == '0);
      pass     = online && !(drop_zero && zero_hit);
   end
endmodule

// File: rtl/hitrec_encode.sv
module hitrec_encode
   import hitrec_pkg::*;
#(
   parameter int unsigned CHAN_W  = 4,
   parameter int unsigned CRATE_W = 5,
   parameter int unsigned CARD_W  = 5,
   parameter int unsigned VAL_W   = 12,
   parameter int unsigned SID_W   = 5,
   parameter int unsigned LID_W   = 14,
   localparam int unsigned LOC_W  = CRATE_W + CARD_W + CHAN_W + VAL_W,
   localparam int unsigned PAD_W  = WORD_W - LOC_W
) (
   input  logic [LID_W-1:0]   modid,
   input  logic [CRATE_W-1:0] crate,
   input  logic [CARD_W-1:0]  card,
   input  logic [CHAN_W-1:0]  chan,
   input  logic [VAL_W-1:0]   value,
   input  phase_e             phase,
   output logic               need_long,
   output logic [WORD_W-1:0]  word,
   output logic               last
);
   logic [LOC_W-1:0]  locator;
   logic [WORD_W-1:0] short_word;
   logic [WORD_W-1:0] head_word;
   logic [WORD_W-1:0] body_word;

   generate
      if (LID_W > SID_W) begin : g_wide_id
         assign need_long = |modid[LID_W-1:SID_W];
      end else begin : g_narrow_id
         assign need_long = 1'b0;
      end
   endgenerate

   always_comb begin
      locator    = {crate, card, chan, value};
      short_word = {1'b1, modid[SID_W-1:0], locator};
      head_word  = {1'b0, modid, LEN_W'(LONG_LEN)};
      body_word  = {PAD_W'(0), locator};
      if (!need_long) begin
         word = short_word;
         last = 1'b1;
      end else if (phase == PH_BODY) begin
         word = body_word;
         last = 1'b1;
      end else begin
         word = head_word;
         last = 1'b0;
      end
   end
endmodule

// File: rtl/hitrec_seq.sv
module hitrec_seq
   import hitrec_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   fire,
   input  logic   last,
   output phase_e phase
);
   phase_e phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_HEAD;
      end else if (fire) begin
         phase_q <= last ? PH_HEAD : PH_BODY;
      end
   end

   assign phase = phase_q;

   assert_body_after_head_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !last) |=> (phase == PH_BODY));
endmodule

// File: rtl/hitrec_packer.sv
module hitrec_packer
   import hitrec_pkg::*;
#(
   parameter int unsigned CHAN_W  = 4,
   parameter int unsigned CRATE_W = 5,
   parameter int unsigned CARD_W  = 5,
   parameter int unsigned VAL_W   = 12,
   parameter int unsigned SID_W   = 5,
   parameter int unsigned LID_W   = 14,
   localparam int unsigned NCHAN  = 1 << CHAN_W,
   localparam int unsigned LOC_W  = CRATE_W + CARD_W + CHAN_W + VAL_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hit_valid,
   output logic               hit_ready,
   input  logic [CHAN_W-1:0]  hit_chan,
   input  logic [CRATE_W-1:0] hit_crate,
   input  logic [CARD_W-1:0]  hit_card,
   input  logic [VAL_W-1:0]   hit_value,
   input  logic [LID_W-1:0]   cfg_modid,
   input  logic [NCHAN-1:0]   cfg_chan_en,
   input  logic               cfg_drop_zero,
   output logic               rec_valid,
   input  logic               rec_ready,
   output logic [WORD_W-1:0]  rec_data,
   output logic               rec_last
);
   generate
      if (1 + SID_W + LOC_W != WORD_W) begin : g_bad_short
         $error("short record fields must fill one word exactly");
      end
      if (1 + LID_W + LEN_W != WORD_W) begin : g_bad_head
         $error("long head fields must fill one word exactly");
      end
      if (LID_W < SID_W) begin : g_bad_id
         $error("long identifier narrower than short identifier");
      end
   endgenerate

   logic        pass;
   logic        need_long;
   logic        word_last;
   logic        fire;
   logic [WORD_W-1:0] word;
   phase_e      phase;

   hitrec_gate #(
      .CHAN_W (CHAN_W),
      .VAL_W  (VAL_W)
   ) u_gate (
      .chan      (hit_chan),
      .value     (hit_value),
      .chan_en   (cfg_chan_en),
      .drop_zero (cfg_drop_zero),
      .pass      (pass)
   );

   hitrec_encode #(
      .CHAN_W  (CHAN_W),
      .CRATE_W (CRATE_W),
      .CARD_W  (CARD_W),
      .VAL_W   (VAL_W),
      .SID_W   (SID_W),
      .LID_W   (LID_W)
   ) u_encode (
      .modid     (cfg_modid),
      .crate     (hit_crate),
      .card      (hit_card),
      .chan      (hit_chan),
      .value     (hit_value),
      .phase     (phase),
      .need_long (need_long),
      .word      (word),
      .last      (word_last)
   );

   hitrec_seq u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (fire),
      .last  (word_last),
      .phase (phase)
   );

   always_comb begin
      rec_valid = rst_n && hit_valid && pass;
      rec_data  = word;
      rec_last  = word_last;
      fire      = rec_valid && rec_ready;
      hit_ready = rst_n && hit_valid && (!pass || (rec_ready && word_last));
   end

   // Properties below take as given that the hit and configuration stay
   // constant until the hit is consumed.
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_data) && $stable(rec_last)));

   assert_back_to_back_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && rec_ready && !rec_last) |=> (rec_valid && rec_last && !rec_data[WORD_W-1]));

   assert_short_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && rec_data[WORD_W-1]) |-> rec_last);

   assert_head_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && !rec_last) |-> (!rec_data[WORD_W-1] && rec_data[LEN_W-1:0] == LEN_W'(LONG_LEN)));

   assert_body_pad_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && rec_last && !rec_data[WORD_W-1]) |-> (rec_data[WORD_W-1:LOC_W] == '0));

   assert_offline_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_valid && !cfg_chan_en[hit_chan]) |-> (!rec_valid && hit_ready));

   assert_zero_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_valid && cfg_drop_zero && hit_value == '0) |-> (!rec_valid && hit_ready));

   assert_accept_final_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_ready && rec_valid) |-> (rec_ready && rec_last));

   always_comb begin
      if (!rst_n) begin
         assert_reset_quiet_R9: assert (!rec_valid && !hit_ready);
      end
   end
endmodule

// File: tb/hitrec_packer_test.sv
module hitrec_packer_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        hit_valid;
   logic        hit_ready;
   logic [3:0]  hit_chan;
   logic [4:0]  hit_crate;
   logic [4:0]  hit_card;
   logic [11:0] hit_value;
   logic [13:0] cfg_modid;
   logic [15:0] cfg_chan_en;
   logic        cfg_drop_zero;
   logic        rec_valid;
   logic        rec_ready;
   logic [31:0] rec_data;
   logic        rec_last;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   hitrec_packer uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .hit_valid     (hit_valid),
      .hit_ready     (hit_ready),
      .hit_chan      (hit_chan),
      .hit_crate     (hit_crate),
      .hit_card      (hit_card),
      .hit_value     (hit_value),
      .cfg_modid     (cfg_modid),
      .cfg_chan_en   (cfg_chan_en),
      .cfg_drop_zero (cfg_drop_zero),
      .rec_valid     (rec_valid),
      .rec_ready     (rec_ready),
      .rec_data      (rec_data),
      .rec_last      (rec_last)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic run_hit(int ch, int cr, int cd, int v, int id, int stall);
      logic [31:0] loc;
      logic [31:0] words [2];
      int nw;
      bit pass;
      hit_chan   = 4'(ch);
      hit_crate  = 5'(cr);
      hit_card   = 5'(cd);
      hit_value  = 12'(v);
      cfg_modid  = 14'(id);
      hit_valid  = 1'b1;
      rec_ready  = 1'b0;
      pass = cfg_chan_en[ch] && !(cfg_drop_zero && v == 0);
      loc = (32'(cr) << 21) | (32'(cd) << 16) | (32'(ch) << 12) | 32'(v);
      if (!pass) begin
         #1;
         if (!cfg_chan_en[ch]) begin
            chk("R5 valid", 32'(rec_valid), 0);
            chk("R5 ready", 32'(hit_ready), 1);
         end else begin
            chk("R6 valid", 32'(rec_valid), 0);
            chk("R6 ready", 32'(hit_ready), 1);
         end
         step();
         hit_valid = 1'b0;
         return;
      end
      if (id < 32) begin
         nw = 1;
         words[0] = 32'h8000_0000 | (32'(id) << 26) | loc;
      end else begin
         nw = 2;
         words[0] = (32'(id) << 17) | 32'd2;
         words[1] = loc;
      end
      for (int w = 0; w < nw; w++) begin
         string tag;
         tag = (nw == 1) ? "R1" : ((w == 0) ? "R2" : "R3");
         for (int s = 0; s < stall; s++) begin
            rec_ready = 1'b0;
            #1;
            chk((w == 1) ? "R4 valid" : "R7 valid", 32'(rec_valid), 1);
            chk("R7 data", rec_data, words[w]);
            chk("R8 ready held", 32'(hit_ready), 0);
            step();
         end
         rec_ready = 1'b1;
         #1;
         chk((w == 1) ? "R4 valid" : tag, 32'(rec_valid), 1);
         chk(tag, rec_data, words[w]);
         chk(tag, 32'(rec_last), (w == nw - 1) ? 1 : 0);
         chk("R8 ready", 32'(hit_ready), (w == nw - 1) ? 1 : 0);
         step();
      end
      hit_valid = 1'b0;
      rec_ready = 1'b0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst_n         = 1'b0;
      hit_valid     = 1'b1;
      rec_ready     = 1'b1;
      hit_chan      = 4'd0;
      hit_crate     = 5'd1;
      hit_card      = 5'd2;
      hit_value     = 12'd3;
      cfg_modid     = 14'd4;
      cfg_chan_en   = 16'hFFFF;
      cfg_drop_zero = 1'b0;
      @(negedge clk);
      #1;
      chk("R9 valid", 32'(rec_valid), 0);
      chk("R9 ready", 32'(hit_ready), 0);
      step();
      #1;
      chk("R9 valid", 32'(rec_valid), 0);
      chk("R9 ready", 32'(hit_ready), 0);
      hit_valid = 1'b0;
      rec_ready = 1'b0;
      step();
      rst_n = 1'b1;
      step();

      cfg_chan_en = 16'b1011_0110_1101_1011;
      for (int dz = 0; dz < 2; dz++) begin
         for (int ii = 0; ii < 4; ii++) begin
            int id;
            id = (ii == 0) ? 0 : (ii == 1) ? 31 : (ii == 2) ? 32 : 16383;
            for (int ch = 0; ch < 16; ch++) begin
               for (int vi = 0; vi < 3; vi++) begin
                  int v;
                  v = (vi == 0) ? 0 : (vi == 1) ? (ch * 257 + 5) % 4096 : 4095;
                  cfg_drop_zero = dz[0];
                  run_hit(ch, (ch * 7 + vi) % 32, (ch * 3 + ii + 1) % 32,
                          v, id, (ch + vi + ii) % 3);
               end
            end
         end
      end

      // all channels online: the enable mask now lets every channel through
      cfg_chan_en   = 16'hFFFF;
      cfg_drop_zero = 1'b0;
      for (int ch = 0; ch < 16; ch++) begin
         run_hit(ch, 31 - ch, ch, 0, 8192 + ch, 0);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule